// File: doc/BRIEF.md
# Expanded-Memory Page Window Translator

This block sits in the address path between the processor and the memory controller. It watches every processor address and decides whether the address falls inside a 64 KB window of four 16 KB pages in the upper-memory area. If it does, and expanded-memory translation is switched on for a memory cycle, the block replaces the upper address bits with the physical frame of that page. The frame is built from the page's position in the window and a 3-bit extension field that supplies address lines 21 to 23. Addresses that miss the window pass through unchanged, apart from the gated line-20 rule used to keep real-mode software below the 1 MB boundary.

A 4-bit window code slides the whole window in 16 KB steps, from C0000H up to D0000H. A second 4-bit code picks the I/O port pair at which software finds the page registers, and the block presents that decoded port base. The block also raises a wait request whenever a translated access happens and the extra-wait option is set. All outputs are registered, so a result appears one clock after its inputs.

Top module: `ems_xlate`

## Requirements
- R1: While reset is high, and at the first clock edge after it, every output (phys_addr, page_hit, wait_req, io_base, io_base_ok) is zero.
- R2: For window code c in 0..4, page p (0..3) hits when cpu_addr[31:14] equals 0x30 + c + p, that is when the address lies in the 16 KB frame starting at C0000H + 16 KB × (c + p).
- R3: Window codes 5 to 15 are reserved and produce no page hit for any address, so the address passes through as described in R7.
- R4: A page hit needs ems_en = 1 and mem_cycle = 1; with either low no hit is produced and the address passes through.
- R5: On a hit for page p, phys_addr[13:0] equals cpu_addr[13:0], phys_addr[15:14] equals p, phys_addr[20:16] is zero, phys_addr[23:21] equals the page's extension field and phys_addr[31:24] is zero.
- R6: Extension fields: ext_a[6:4] belongs to page 0, ext_a[2:0] to page 1, ext_b[6:4] to page 2 and ext_b[2:0] to page 3; bits 3 and 7 of both bytes have no effect on phys_addr.
- R7: Without a hit, phys_addr equals cpu_addr except bit 20, which equals cpu_addr[20] AND (gate_a20 OR bus_master).
- R8: wait_req is 1 exactly when a page hits and ems_wait_en is 1.
- R9: io_code values 0, 1, 5, 6, 10, 11 and 14 give io_base_ok = 1 and io_base = 208H + 10H × io_code (the pair is io_base and io_base + 1); every other code gives io_base_ok = 0 and io_base = 0.
- R10: Each output reflects the inputs sampled at the previous rising clock edge (one cycle latency).
- R11: At most one bit of page_hit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 32 | Processor byte address |
| mem_cycle | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| bus_master | input | 1 | 1 during DMA or bus-master cycles (line-20 gate treated as open) |
| gate_a20 | input | 1 | Line-20 gate; 0 forces address bit 20 low on pass-through |
| ems_en | input | 1 | Expanded-memory translation enable |
| ems_wait_en | input | 1 | Request extra wait states on translated accesses |
| win_code | input | 4 | Window placement code |
| io_code | input | 4 | Page-register I/O port pair code |
| ext_a | input | 8 | Extension fields of pages 0 and 1 |
| ext_b | input | 8 | Extension fields of pages 2 and 3 |
| phys_addr | output | 32 | Translated or passed-through address |
| page_hit | output | 4 | One bit per window page, set on a hit |
| wait_req | output | 1 | Extra wait-state request for the current access |
| io_base | output | 16 | Lower port of the page-register pair |
| io_base_ok | output | 1 | 1 when io_code is a supported code |

## Verification
A wrong frame comparison shows up as a hit on the neighbouring 16 KB frame or as a missing hit, visible on page_hit one cycle after the address is applied; a crossed extension field shows only in phys_addr[23:21] for the page whose field was swapped. Broken line-20 gating only becomes visible on missing addresses with bit 20 set, so the sweeps include such addresses under every gate and bus-master combination. A wrong port decode is seen on io_base the cycle after io_code changes.

// File: rtl/ems_xlate_pkg.sv
package ems_xlate_pkg;

  localparam int NPAGE   = 4;
  localparam int EXT_W   = 3;
  localparam int EXTBUS_W = 16;

  // Extension field of page p in the concatenated bus {ext_b, ext_a}.
  // Odd pages sit in the low nibble, even pages in the high nibble.
  function automatic logic [EXT_W-1:0] ext_field(input logic [EXTBUS_W-1:0] bus,
                                                 input int p);
    int off;
    off = (p / 2) * 8 + (((p % 2) != 0) ? 0 : 4);
    return bus[off +: EXT_W];
  endfunction

  // Code support lookup from a bit mask.
  function automatic logic code_supported(input logic [15:0] mask,
                                          input logic [3:0] code);
    return mask[code];
  endfunction

  // Frame index of page p for window code c.
  function automatic int frame_of(input int frame0, input int c, input int p);
    return frame0 + c + p;
  endfunction

endpackage

// File: rtl/ems_win_match.sv
module ems_win_match
  import ems_xlate_pkg::*;
#(
  parameter int FRAME_W  = 18,
  parameter int FRAME0   = 'h30,
  parameter int MAX_CODE = 4,
  parameter int CODE_W   = 4
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic [CODE_W-1:0]  code,
  input  logic               active,
  output logic               win_ok,
  output logic [NPAGE-1:0]   hit
);

  assign win_ok = (int'(code) <= MAX_CODE);

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    logic [FRAME_W-1:0] target;
    assign target = FRAME_W'(FRAME0) + FRAME_W'(code) + FRAME_W'(p);
    assign hit[p] = active && win_ok && (frame == target);
  end

endmodule

// File: rtl/ems_io_dec.sv
module ems_io_dec
  import ems_xlate_pkg::*;
#(
  parameter int          IO_W       = 16,
  parameter int          BASE0      = 'h208,
  parameter int          STEP_SHIFT = 4,
  parameter logic [15:0] CODE_MASK  = 16'h4C63
) (
  input  logic [3:0]      code,
  output logic [IO_W-1:0] base,
  output logic            ok
);

  assign ok   = code_supported(CODE_MASK, code);
  assign base = ok ? (IO_W'(BASE0) + (IO_W'(code) << STEP_SHIFT)) : '0;

endmodule

// File: rtl/ems_addr_form.sv
module ems_addr_form
  import ems_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 14,
  parameter int EXT_LSB    = 21,
  parameter int GATE_BIT   = 20
) (
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [NPAGE-1:0]    hit,
  input  logic [EXTBUS_W-1:0] ext_bus,
  input  logic                gate_open,
  output logic [ADDR_W-1:0]   phys
);

  localparam int IDX_W = $clog2(NPAGE);

  logic [IDX_W-1:0] idx;
  logic [EXT_W-1:0] ext;

  always_comb begin
    idx = '0;
    ext = '0;
    for (int p = 0; p < NPAGE; p++) begin
      if (hit[p]) begin
        idx = IDX_W'(p);
        ext = ext_field(ext_bus, p);
      end
    end
  end

  always_comb begin
    if (|hit) begin
      phys = '0;
      phys[PAGE_SHIFT-1:0]     = cpu_addr[PAGE_SHIFT-1:0];
      phys[PAGE_SHIFT +: IDX_W] = idx;
      phys[EXT_LSB +: EXT_W]   = ext;
    end else begin
      phys = cpu_addr;
      phys[GATE_BIT] = cpu_addr[GATE_BIT] & gate_open;
    end
  end

endmodule

// File: rtl/ems_xlate.sv
module ems_xlate
  import ems_xlate_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_SHIFT = 14,
  parameter int          FRAME0     = 'h30,
  parameter int          MAX_CODE   = 4,
  parameter int          IO_W       = 16,
  parameter int          IO_BASE0   = 'h208,
  parameter int          IO_SHIFT   = 4,
  parameter logic [15:0] IO_MASK    = 16'h4C63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mem_cycle,
  input  logic              bus_master,
  input  logic              gate_a20,
  input  logic              ems_en,
  input  logic              ems_wait_en,
  input  logic [3:0]        win_code,
  input  logic [3:0]        io_code,
  input  logic [7:0]        ext_a,
  input  logic [7:0]        ext_b,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [3:0]        page_hit,
  output logic              wait_req,
  output logic [IO_W-1:0]   io_base,
  output logic              io_base_ok
);

  localparam int FRAME_W = ADDR_W - PAGE_SHIFT;

  // Internal events brought out for the checker.
  logic                xl_active;
  logic                win_ok;
  logic [NPAGE-1:0]    hit_vec;
  logic                any_hit;
  logic                gate_open;
  logic [ADDR_W-1:0]   phys_nxt;
  logic [IO_W-1:0]     io_nxt;
  logic                io_ok_nxt;

  assign xl_active = ems_en && mem_cycle;
  assign gate_open = gate_a20 || bus_master;

  ems_win_match #(
    .FRAME_W (FRAME_W),
    .FRAME0  (FRAME0),
    .MAX_CODE(MAX_CODE),
    .CODE_W  (4)
  ) u_match (
    .frame (cpu_addr[ADDR_W-1:PAGE_SHIFT]),
    .code  (win_code),
    .active(xl_active),
    .win_ok(win_ok),
    .hit   (hit_vec)
  );

  assign any_hit = |hit_vec;

  ems_addr_form #(
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .EXT_LSB   (21),
    .GATE_BIT  (20)
  ) u_form (
    .cpu_addr (cpu_addr),
    .hit      (hit_vec),
    .ext_bus  ({ext_b, ext_a}),
    .gate_open(gate_open),
    .phys     (phys_nxt)
  );

  ems_io_dec #(
    .IO_W      (IO_W),
    .BASE0     (IO_BASE0),
    .STEP_SHIFT(IO_SHIFT),
    .CODE_MASK (IO_MASK)
  ) u_io (
    .code(io_code),
    .base(io_nxt),
    .ok  (io_ok_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr  <= '0;
      page_hit   <= '0;
      wait_req   <= 1'b0;
      io_base    <= '0;
      io_base_ok <= 1'b0;
    end else begin
      phys_addr  <= phys_nxt;
      page_hit   <= hit_vec;
      wait_req   <= any_hit && ems_wait_en;
      io_base    <= io_nxt;
      io_base_ok <= io_ok_nxt;
    end
  end

endmodule

// File: rtl/ems_xlate_chk.sv
module ems_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cpu_addr,
  input logic        mem_cycle,
  input logic        bus_master,
  input logic        gate_a20,
  input logic        ems_en,
  input logic        ems_wait_en,
  input logic [3:0]  win_code,
  input logic [31:0] phys_addr,
  input logic [3:0]  page_hit,
  input logic        wait_req,
  input logic [15:0] io_base,
  input logic        io_base_ok
);

  // R11
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(page_hit));

  // R4
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (page_hit != 4'b0) |-> $past(ems_en && mem_cycle));

  // R3
  reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(win_code) > 4'd4) |-> (page_hit == 4'b0));

  // R5
  offset_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (page_hit != 4'b0) |-> (phys_addr[13:0] == $past(cpu_addr[13:0])));

  // R8
  wait_only_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    wait_req |-> ((page_hit != 4'b0) && $past(ems_wait_en)));

  // R7
  a20_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ((page_hit == 4'b0) && !$past(gate_a20) && !$past(bus_master)) |-> !phys_addr[20]);

  // R9
  io_pair_align_chk: assert property (@(posedge clk) disable iff (rst)
    io_base_ok |-> (io_base[3:0] == 4'h8));

endmodule

bind ems_xlate ems_xlate_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_addr   (cpu_addr),
  .mem_cycle  (mem_cycle),
  .bus_master (bus_master),
  .gate_a20   (gate_a20),
  .ems_en     (ems_en),
  .ems_wait_en(ems_wait_en),
  .win_code   (win_code),
  .phys_addr  (phys_addr),
  .page_hit   (page_hit),
  .wait_req   (wait_req),
  .io_base    (io_base),
  .io_base_ok (io_base_ok)
);

// File: tb/ems_xlate_test.sv
module ems_xlate_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] cpu_addr;
  logic        mem_cycle, bus_master, gate_a20, ems_en, ems_wait_en;
  logic [3:0]  win_code, io_code;
  logic [7:0]  ext_a, ext_b;
  logic [31:0] phys_addr;
  logic [3:0]  page_hit;
  logic        wait_req;
  logic [15:0] io_base;
  logic        io_base_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ems_xlate uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mem_cycle(mem_cycle),
    .bus_master(bus_master), .gate_a20(gate_a20), .ems_en(ems_en),
    .ems_wait_en(ems_wait_en), .win_code(win_code), .io_code(io_code),
    .ext_a(ext_a), .ext_b(ext_b), .phys_addr(phys_addr), .page_hit(page_hit),
    .wait_req(wait_req), .io_base(io_base), .io_base_ok(io_base_ok)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Expected extension of page p, written per page.
  function automatic logic [2:0] exp_ext(input int p, input logic [7:0] a, input logic [7:0] b);
    case (p)
      0: return a[6:4];
      1: return a[2:0];
      2: return b[6:4];
      default: return b[2:0];
    endcase
  endfunction

  // Expected outputs from the requirements, by address arithmetic.
  task automatic expect_out(output logic [3:0] e_hit, output logic [31:0] e_phys,
                            output logic e_wait);
    longint start;
    int p;
    e_hit = 4'b0;
    start = 64'hC0000 + longint'(win_code) * 64'h4000;
    e_phys = cpu_addr;
    if (ems_en && mem_cycle && win_code <= 4 &&
        longint'(cpu_addr) >= start && longint'(cpu_addr) < start + 64'h10000) begin
      p = int'((longint'(cpu_addr) - start) / 64'h4000);
      e_hit[p] = 1'b1;
      e_phys = {8'h0, exp_ext(p, ext_a, ext_b), 5'h0, 2'(p), cpu_addr[13:0]};
    end else if (!(gate_a20 || bus_master)) begin
      e_phys[20] = 1'b0;
    end
    e_wait = (e_hit != 0) && ems_wait_en;
  endtask

  task automatic apply_and_check(input string tag);
    logic [3:0] eh; logic [31:0] ep; logic ew;
    expect_out(eh, ep, ew);
    @(negedge clk);
    check({tag, " hit"},  32'(page_hit), 32'(eh));
    check({tag, " addr"}, phys_addr, ep);
    check({"R8 ", tag},   32'(wait_req), 32'(ew));
  endtask

  function automatic logic [15:0] exp_io(input int c);
    case (c)
      0: return 16'h208;  1: return 16'h218;  5: return 16'h258;
      6: return 16'h268;  10: return 16'h2A8; 11: return 16'h2B8;
      14: return 16'h2E8; default: return 16'h0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; cpu_addr = 32'hC1234; mem_cycle = 1; bus_master = 0; gate_a20 = 1;
    ems_en = 1; ems_wait_en = 1; win_code = 0; io_code = 0; ext_a = 8'h77; ext_b = 8'h77;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 phys", phys_addr, 32'h0);
    check("R1 hit", 32'(page_hit), 32'h0);
    check("R1 wait", 32'(wait_req), 32'h0);
    check("R1 io", 32'(io_base), 32'h0);
    check("R1 io_ok", 32'(io_base_ok), 32'h0);
    rst = 0;

    // R2 R3 R5 R6 R10: sweep window codes over frames around the window
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 12; k++) begin
        win_code = 4'(c);
        ext_a = 8'((c * 37 + k * 11) ^ 8'h88);
        ext_b = 8'((c * 53 + k * 7) | 8'h88);
        cpu_addr = 32'hB8000 + 32'(k) * 32'h4000 + 32'((k * 997) & 16'h3FFF);
        ems_wait_en = k[0];
        apply_and_check(c <= 4 ? "R2 R5 R6" : "R3");
      end
    end

    // R6: reserved extension bits ignored
    win_code = 0; cpu_addr = 32'hC4010; ext_a = 8'h05; ext_b = 8'h00;
    apply_and_check("R6 a");
    ext_a = 8'h8D;
    apply_and_check("R6 b");

    // R4: enable and cycle type
    for (int m = 0; m < 4; m++) begin
      ems_en = m[0]; mem_cycle = m[1]; cpu_addr = 32'hCC3FF; win_code = 0;
      apply_and_check("R4");
    end
    ems_en = 1; mem_cycle = 1;

    // R2: upper address bits above 1 MB never alias into the window
    cpu_addr = 32'h010C0000; apply_and_check("R2 alias");

    // R7: gating of bit 20 on pass-through
    for (int g = 0; g < 8; g++) begin
      gate_a20 = g[0]; bus_master = g[1];
      cpu_addr = g[2] ? 32'h001FFFFF : 32'h0013C000;
      win_code = 4'd15;
      apply_and_check("R7");
    end
    gate_a20 = 1; bus_master = 0;

    // R9: I/O port pair decode
    for (int c = 0; c < 16; c++) begin
      io_code = 4'(c);
      @(negedge clk);
      check("R9 base", 32'(io_base), 32'(exp_io(c)));
      check("R9 ok", 32'(io_base_ok), 32'(exp_io(c) != 0));
    end

    // R10: output changes only after the clock edge
    win_code = 0; cpu_addr = 32'hC8000; ext_a = 0; ext_b = 8'h50;
    @(negedge clk);
    cpu_addr = 32'h00000123;
    #1;
    check("R10 hold", 32'(page_hit), 32'h4);
    @(negedge clk);
    check("R10 update", 32'(page_hit), 32'h0);

    // R1: reset clears after activity
    cpu_addr = 32'hD0000; win_code = 4; rst = 1;
    @(negedge clk);
    check("R1 again", 32'(page_hit), 32'h0);
    rst = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule